// File: doc/BRIEF.md
# Watchdog Timer with Ordered Feed Sequence

This block guards a processor against runaway software. A selectable count source drives a 12-bit prescaler, and one of its taps decrements an 8-bit down counter. Software must restart the count in time by writing two fixed key bytes to two feed registers, in order. If the counter runs out while watchdog mode is active, the block pulses a system reset for one cycle and sets a timeout flag. With watchdog mode off, the same counter serves as an interval timer: running out sets the flag and raises an interrupt instead.

Writes to the control register do not act at once. They land in a pending copy, which becomes active only when the next valid feed completes. While watchdog mode is active, any broken feed sequence and any control write that is not followed straight away by a feed reset the system. Once watchdog mode has been switched on, only the power-on reset can switch it off. The oscillators are outside the block and arrive as one-cycle enable strobes on the block clock.

Top module: `feed_watchdog`

## Requirements
- R1: A write of 0xA5 to the first feed register (address 2), followed by a write of 0x5A to the second feed register (address 3) as the very next write, completes a feed. The feed loads the down counter from the reload register (address 1), clears the prescaler and clears the crystal divider. The first underflow then comes P*(R+1) source ticks after the feed write, where R is the reload value and P is the tap period.
- R2: The tap field is control bits [7:5], value k. It makes the counter decrement once every 2^(k+5) source ticks, so tap 0 gives 32 ticks and tap 7 gives 4096 ticks.
- R3: Control bits [1:0] choose the source: 0 and 3 use `pclk_en`, 1 uses `wdosc_en`, and 2 uses `xtal_en` divided by 32.
- R4: While the `pclk_en` source is selected and `cpu_pd` is high, the prescaler and the counter hold their values. Counting resumes from the held state when `cpu_pd` falls.
- R5: In watchdog mode, a sequence error pulses `sys_rst` in the cycle after the offending write. A sequence error is any of: a first-feed write whose value is not 0xA5, a second-feed write that does not directly follow a good first feed, or any other write between the two feed bytes. In timer mode the same writes abandon the sequence and cause no reset.
- R6: In watchdog mode, after a control write (address 0) the next write must be the 0xA5 first-feed byte. Any other write pulses `sys_rst`.
- R7: The control fields do not take effect until a feed completes. These fields are tap, watchdog mode (bit 4), run (bit 3) and source. Until then the counter keeps its previous tap, source and run state. The counter counts when run is set or watchdog mode is active.
- R8: In watchdog mode, an underflow drives `sys_rst` high for exactly one cycle, sets `timeout_flag` and reloads the counter.
- R9: In timer mode, an underflow sets `timeout_flag` and raises `irq`, and `sys_rst` stays low. `irq` equals the flag while watchdog mode is inactive and is low while it is active.
- R10: Watchdog mode, once active, stays active through any later control write and feed, and clears only on `rst_n`.
- R11: `timeout_flag` is not cleared by `sys_rst`. It clears on `rst_n`, or at once when the control register is written with bit 2 low.
- R12: After `rst_n`, the reload register and the counter hold 0xFF, the control is tap 7, timer mode, stopped, `pclk_en` source, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 reload, 2 first feed, 3 second feed |
| wr_data | input | 8 | Write data |
| pclk_en | input | 1 | Peripheral clock enable strobe |
| wdosc_en | input | 1 | Watchdog oscillator enable strobe |
| xtal_en | input | 1 | Low-speed crystal enable strobe |
| cpu_pd | input | 1 | CPU powered down |
| sys_rst | output | 1 | One-cycle system reset pulse |
| timeout_flag | output | 1 | Underflow flag |
| irq | output | 1 | Interval timer interrupt |

## Verification
A wrong prescaler tap, source selection or reload value changes the distance from a feed to the next underflow. That distance is measured to the exact cycle for each tap, source and reload combination, so the error shows up no later than the first expected underflow. A feed sequencer in the wrong state shows up one cycle after the next write, as a reset pulse that should not be there or one that is missing. A shadow register that leaks into the active control shows up within one tap period after a control write made without a feed.

// File: rtl/fwd_pkg.sv
// Shared constants and types for the feed watchdog.
// Assumes an 8-bit register write bus with a 2-bit address.
package fwd_pkg;
    localparam int DATA_W = 8;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_FEED1  = 2'd2;
    localparam logic [1:0] ADDR_FEED2  = 2'd3;

    localparam logic [DATA_W-1:0] FEED_KEY1 = 8'hA5;
    localparam logic [DATA_W-1:0] FEED_KEY2 = 8'h5A;

    localparam logic [1:0] SRC_PCLK  = 2'd0;
    localparam logic [1:0] SRC_WDOSC = 2'd1;
    localparam logic [1:0] SRC_XTAL  = 2'd2;

    // Active control fields. Bit 2 of a control write is the flag clear and is not stored.
    typedef struct packed {
        logic [2:0] tap;
        logic       wd_mode;
        logic       run;
        logic [1:0] src;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{tap: 3'd7, wd_mode: 1'b0, run: 1'b0, src: SRC_PCLK};
endpackage

// File: rtl/fwd_tick_sel.sv
// Source tick selection for the feed watchdog.
// Picks one of three enable strobes. The crystal strobe is divided by 2**XDIV_W.
// The peripheral strobe is blocked while the CPU is powered down.
// Assumes every strobe is already synchronous to clk.
module fwd_tick_sel #(
    parameter int XDIV_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] src,
    input  logic       pclk_en,
    input  logic       wdosc_en,
    input  logic       xtal_en,
    input  logic       cpu_pd,
    output logic       src_tick
);
    import fwd_pkg::*;

    logic xtal_tick;

    generate
        if (XDIV_W == 0) begin : g_nodiv
            assign xtal_tick = xtal_en;
        end else begin : g_div
            logic [XDIV_W-1:0] xdiv_q;
            // Divide the crystal strobe; a feed restarts the divider phase.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)  xdiv_q <= '0;
                else if (xtal_en)   xdiv_q <= xdiv_q + 1'b1;
            end
            assign xtal_tick = xtal_en && (&xdiv_q);
        end
    endgenerate

    // Route the selected source; the peripheral clock stops during CPU power-down.
    always_comb begin
        case (src)
            SRC_WDOSC: src_tick = wdosc_en;
            SRC_XTAL:  src_tick = xtal_tick;
            default:   src_tick = pclk_en && !cpu_pd;
        endcase
    end

    p_pd_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((src == SRC_PCLK || src == 2'd3) && cpu_pd) |-> !src_tick);
endmodule

// File: rtl/fwd_feed_seq.sv
// Feed sequence tracker for the feed watchdog.
// Accepts the two-byte ordered feed. It flags any write that breaks the
// sequence, and any control write that is not followed by the first key.
// Assumes at most one write per cycle.
module fwd_feed_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       feed_ok,
    output logic       seq_err
);
    import fwd_pkg::*;

    typedef enum logic [1:0] {S_IDLE, S_NEED1, S_GOT1} seq_e;
    seq_e st_q, st_d;

    // Work out the next sequence state and the result of the current write.
    always_comb begin
        st_d    = st_q;
        feed_ok = 1'b0;
        seq_err = 1'b0;
        if (wr_en) begin
            case (st_q)
                S_IDLE: begin
                    if (wr_addr == ADDR_CTRL) begin
                        st_d = S_NEED1;
                    end else if (wr_addr == ADDR_FEED1) begin
                        if (wr_data == FEED_KEY1) st_d = S_GOT1;
                        else                      seq_err = 1'b1;
                    end else if (wr_addr == ADDR_FEED2) begin
                        seq_err = 1'b1;
                    end
                end
                S_NEED1: begin
                    if (wr_addr == ADDR_FEED1 && wr_data == FEED_KEY1) begin
                        st_d = S_GOT1;
                    end else begin
                        seq_err = 1'b1;
                        st_d    = (wr_addr == ADDR_CTRL) ? S_NEED1 : S_IDLE;
                    end
                end
                S_GOT1: begin
                    if (wr_addr == ADDR_FEED2 && wr_data == FEED_KEY2) begin
                        feed_ok = 1'b1;
                        st_d    = S_IDLE;
                    end else begin
                        seq_err = 1'b1;
                        st_d    = (wr_addr == ADDR_CTRL) ? S_NEED1 : S_IDLE;
                    end
                end
                default: st_d = S_IDLE;
            endcase
        end
    end

    // Hold the sequence state.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    p_ok_not_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(feed_ok && seq_err));
    p_ok_only_from_got1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        feed_ok |=> (st_q == S_IDLE));
endmodule

// File: rtl/fwd_counter.sv
// Prescaler and down counter for the feed watchdog.
// The prescaler counts source ticks. When the low (TAP_BASE+tap) bits of the
// prescaler are all ones on a tick, the down counter decrements. An
// underflow reloads the counter. A load clears the prescaler and reloads the counter.
module fwd_counter #(
    parameter int PRE_W = 12,
    parameter int TAP_W = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic             run,
    input  logic [TAP_W-1:0] tap,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             load,
    output logic             underflow
);
    localparam int N_TAPS   = 2 ** TAP_W;
    localparam int TAP_BASE = PRE_W - N_TAPS + 1;

    logic [PRE_W-1:0]  pre_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [N_TAPS-1:0] tap_hit;
    logic              step;
    logic              dec;

    genvar gi;
    generate
        for (gi = 0; gi < N_TAPS; gi++) begin : g_tap
            assign tap_hit[gi] = &pre_q[TAP_BASE+gi-1:0];
        end
    endgenerate

    assign step      = src_tick && run;
    assign dec       = step && tap_hit[tap];
    assign underflow = dec && (cnt_q == '0) && !load;

    // Advance the prescaler on each enabled source tick.
    always_ff @(posedge clk) begin
        if (!rst_n || load) pre_q <= '0;
        else if (step)      pre_q <= pre_q + 1'b1;
    end

    // Decrement the counter on tap hits and reload it on a load or an underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '1;
        else if (load)      cnt_q <= reload_val;
        else if (dec)       cnt_q <= (cnt_q == '0) ? reload_val : cnt_q - 1'b1;
    end

    p_feed_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(reload_val)));
    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_tick && !load) |=> ($stable(pre_q) && $stable(cnt_q)));
    p_uf_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (cnt_q == $past(reload_val)));
endmodule

// File: rtl/feed_watchdog.sv
// Feed watchdog top level.
// Holds the pending and active control, the reload register and the timeout flag.
// Turns sequence errors and underflows into a one-cycle reset pulse in
// watchdog mode, or into an interrupt in timer mode.
// Assumes a synchronous active-low power-on reset and strobes synchronous to clk.
module feed_watchdog #(
    parameter int PRE_W  = 12,
    parameter int TAP_W  = 3,
    parameter int XDIV_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       pclk_en,
    input  logic       wdosc_en,
    input  logic       xtal_en,
    input  logic       cpu_pd,
    output logic       sys_rst,
    output logic       timeout_flag,
    output logic       irq
);
    import fwd_pkg::*;

    localparam int CNT_W = DATA_W;

    ctrl_t            ctrl_act, ctrl_pend;
    logic [CNT_W-1:0] reload_q;
    logic             feed_ok, seq_err, src_tick, underflow;
    logic             ctrl_wr, reload_wr;

    assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
    assign reload_wr = wr_en && (wr_addr == ADDR_RELOAD);

    fwd_feed_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .feed_ok (feed_ok),
        .seq_err (seq_err)
    );

    fwd_tick_sel #(.XDIV_W(XDIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (feed_ok),
        .src      (ctrl_act.src),
        .pclk_en  (pclk_en),
        .wdosc_en (wdosc_en),
        .xtal_en  (xtal_en),
        .cpu_pd   (cpu_pd),
        .src_tick (src_tick)
    );

    fwd_counter #(.PRE_W(PRE_W), .TAP_W(TAP_W), .CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_tick   (src_tick),
        .run        (ctrl_act.run || ctrl_act.wd_mode),
        .tap        (ctrl_act.tap),
        .reload_val (reload_q),
        .load       (feed_ok),
        .underflow  (underflow)
    );

    // Capture control writes into the pending copy.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_pend <= CTRL_RST;
        else if (ctrl_wr) ctrl_pend <= '{tap: wr_data[7:5], wd_mode: wr_data[4],
                                         run: wr_data[3], src: wr_data[1:0]};
    end

    // Move the pending control into use on a valid feed; watchdog mode is sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_act <= CTRL_RST;
        end else if (feed_ok) begin
            ctrl_act         <= ctrl_pend;
            ctrl_act.wd_mode <= ctrl_pend.wd_mode || ctrl_act.wd_mode;
        end
    end

    // Hold the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '1;
        else if (reload_wr) reload_q <= wr_data;
    end

    // Set the flag on underflow; a control write with bit 2 low clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                      timeout_flag <= 1'b0;
        else if (underflow)              timeout_flag <= 1'b1;
        else if (ctrl_wr && !wr_data[2]) timeout_flag <= 1'b0;
    end

    // Register the one-cycle system reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) sys_rst <= 1'b0;
        else        sys_rst <= ctrl_act.wd_mode && (seq_err || underflow);
    end

    assign irq = timeout_flag && !ctrl_act.wd_mode;

    p_err_resets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && ctrl_act.wd_mode) |=> sys_rst);
    p_wd_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_act.wd_mode |=> ctrl_act.wd_mode);
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !feed_ok |=> $stable(ctrl_act));
    p_tof_on_uf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> timeout_flag);
    p_no_rst_timer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_act.wd_mode |=> !sys_rst);
endmodule

// File: tb/test_feed_watchdog.sv
// Self-checking bench for feed_watchdog: directed corner cases plus seeded random timer runs.
module test_feed_watchdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pclk_en = 1'b1;
    logic       wdosc_en = 1'b0;
    logic       xtal_en = 1'b1;
    logic       cpu_pd = 1'b0;
    logic       sys_rst, timeout_flag, irq;

    int checks = 0;
    int errors = 0;

    feed_watchdog i_feed_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pclk_en(pclk_en), .wdosc_en(wdosc_en), .xtal_en(xtal_en), .cpu_pd(cpu_pd),
        .sys_rst(sys_rst), .timeout_flag(timeout_flag), .irq(irq)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            wdosc_en = ~wdosc_en;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic int exp_cycles(input int tap, input int rl, input int src);
        int base;
        base = (32 << tap) * (rl + 1);
        if (src == 2) return base * 32;
        if (src == 1) return base * 2;
        return base;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic feed();
        wr(2'd2, 8'hA5);
        wr(2'd3, 8'h5A);
    endtask

    task automatic wait_evt(input bit want_rst, input int limit,
                            output int n, output bit saw_rst, output bit saw_irq);
        n = 0; saw_rst = 1'b0; saw_irq = 1'b0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (sys_rst) saw_rst = 1'b1;
            if (irq) saw_irq = 1'b1;
            if (want_rst ? sys_rst : irq) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic por();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int n, e;
        bit sr, si;
        void'($urandom(32'd1234));
        por();

        // R12 reset state
        chk(sys_rst == 0 && timeout_flag == 0 && irq == 0, "R12 outputs after reset", {sys_rst, timeout_flag, irq}, 0);
        wait_evt(1'b0, 300, n, sr, si);
        chk(!si && !sr, "R12 stopped after reset", {sr, si}, 0);
        wr(2'd0, 8'h0C);
        feed();
        wait_evt(1'b0, 9000, n, sr, si);
        chk(n == 8192, "R12 reload resets to 0xFF", n, 8192);

        // R1 R2 R9 timer mode, tap 0, reload 3
        wr(2'd1, 8'd3);
        wr(2'd0, 8'h08);
        feed();
        wait_evt(1'b0, 1000, n, sr, si);
        chk(n == 128, "R1 R2 timer underflow distance", n, 128);
        chk(!sr, "R9 no reset in timer mode", sr, 0);
        chk(timeout_flag == 1 && irq == 1, "R9 flag and irq", {timeout_flag, irq}, 3);

        // R11 software clear
        wr(2'd0, 8'h08);
        chk(timeout_flag == 0 && irq == 0, "R11 clear by control write", timeout_flag, 0);
        feed();

        // R3 R2 random source, tap, reload
        for (int it = 0; it < 6; it++) begin
            int tp, rl, sc;
            tp = $urandom_range(0, 1);
            rl = $urandom_range(0, 3);
            sc = $urandom_range(0, 2);
            wr(2'd1, 8'(rl));
            wr(2'd0, 8'((tp << 5) | 8'h08 | sc));
            feed();
            e = exp_cycles(tp, rl, sc);
            wait_evt(1'b0, 9000, n, sr, si);
            if (sc == 1) chk(n == e || n == e - 1, "R3 wdosc source period", n, e);
            else         chk(n == e, "R3 source and tap period", n, e);
        end

        // R4 peripheral clock frozen during CPU power-down
        wr(2'd1, 8'd0);
        wr(2'd0, 8'h08);
        @(negedge clk); cpu_pd = 1'b1;
        feed();
        wait_evt(1'b0, 200, n, sr, si);
        chk(!si, "R4 no count while powered down", si, 0);
        @(negedge clk); cpu_pd = 1'b0;
        wait_evt(1'b0, 200, n, sr, si);
        chk(n == 32, "R4 resumes from held state", n, 32);

        // R7 shadow: control write without feed keeps old tap
        wr(2'd0, 8'h08);
        feed();
        wait_evt(1'b0, 200, n, sr, si);
        chk(n == 32, "R7 baseline tap 0", n, 32);
        wr(2'd0, 8'hE8);
        wait_evt(1'b0, 200, n, sr, si);
        chk(n == 30, "R7 pending tap not yet active", n, 30);
        wr(2'd0, 8'hE8);
        feed();
        wait_evt(1'b0, 5000, n, sr, si);
        chk(n == 4096, "R7 R2 tap 7 after feed", n, 4096);

        // R8 watchdog underflow
        wr(2'd1, 8'd2);
        wr(2'd0, 8'h18);
        feed();
        wait_evt(1'b1, 500, n, sr, si);
        chk(n == 96, "R8 watchdog underflow distance", n, 96);
        chk(timeout_flag == 1 && irq == 0, "R8 flag set, irq masked", {timeout_flag, irq}, 2);
        @(negedge clk);
        chk(sys_rst == 0, "R8 reset pulse one cycle", sys_rst, 0);
        chk(timeout_flag == 1, "R11 flag survives reset pulse", timeout_flag, 1);

        // R10 watchdog mode cannot be turned off
        wr(2'd0, 8'h08);
        feed();
        wait_evt(1'b1, 500, n, sr, si);
        chk(n == 96 && !si, "R10 still watchdog mode", n, 96);

        // R5 R6 sequence errors in watchdog mode
        feed();
        wr(2'd3, 8'h5A);
        chk(sys_rst == 1, "R5 reversed feed resets", sys_rst, 1);
        feed();
        wr(2'd2, 8'hA5);
        chk(sys_rst == 0, "R5 first key alone no reset", sys_rst, 0);
        wr(2'd1, 8'd2);
        chk(sys_rst == 1, "R5 foreign write between keys", sys_rst, 1);
        feed();
        wr(2'd2, 8'h55);
        chk(sys_rst == 1, "R5 wrong first key", sys_rst, 1);
        feed();
        wr(2'd0, 8'h18);
        chk(sys_rst == 0, "R6 control write alone", sys_rst, 0);
        wr(2'd1, 8'd2);
        chk(sys_rst == 1, "R6 control write not followed by feed", sys_rst, 1);
        feed();
        chk(sys_rst == 0, "R1 good feed no reset", sys_rst, 0);

        // R11 R10 R5 power-on reset clears flag and mode; timer mode tolerates errors
        por();
        chk(timeout_flag == 0 && irq == 0, "R11 flag cleared by power-on reset", timeout_flag, 0);
        wr(2'd3, 8'h5A);
        chk(sys_rst == 0, "R5 R10 timer mode error no reset", sys_rst, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule